// File: doc/BRIEF.md
# Address-space identifier context decoder

This block sits in a load/store unit in front of the translation lookaside buffer. For every access it turns the 8-bit address-space identifier (ASI), the access kind, the privilege bit and the trap level into the settings that the translation step needs. These settings are a translation mode index, a 13-bit context number, a user/privileged flag, a byte-order flag, a secondary-space flag and a no-fault flag. It also shows when a data access skips translation because the data MMU is off. A lookup-failed input, sampled with the access, marks a no-fault load whose result must be forced to zero and that must not trap.

The block samples the inputs on a cycle where `in_valid` is high. The decoded result appears one clock later, together with `out_valid`. Identifiers outside the decoded set raise an unhandled flag so that the surrounding unit can send them to its alternate-space or trap path.

Top module: `asi_ctx_decoder`

## Requirements
- R1: The mode output uses user=0, kernel=1, hypervisor=2, nucleus=3, user-secondary=4, kernel-secondary=5 and none=7. After reset every output is 0, including mode, and `out_valid` is low.
- R2: For a load or store (kind 0 or 1), ASI 0x04 or 0x0C selects nucleus mode (3) with context 0.
- R3: For a load or store, ASIs 0x10, 0x11, 0x18 and 0x19 select user mode (0) or user-secondary mode (4), whatever the value of `priv`.
- R4: For a load or store, ASIs 0x80, 0x81, 0x88 and 0x89 select kernel (1) or kernel-secondary (5) when `priv`=1, and user (0) or user-secondary (4) when `priv`=0.
- R5: In these groups, ASI bit 0 = 1 selects secondary space. Then `secondary`=1 and the context is the low 13 bits of `sec_ctx`. Primary modes (0, 1) take the low 13 bits of `pri_ctx`.
- R6: For a load (kind 0), ASIs 0x82, 0x83, 0x8A and 0x8B decode as in R4 with `nofault`=1. `nf_zero` is 1 when `lookup_fail` is 1 and the access is not bypassed. For a store, these ASIs are unhandled.
- R7: A decoded load or store with `dmmu_en`=0 asserts `bypass`. All other outputs are the same as with the data MMU on. An instruction fetch never asserts `bypass`.
- R8: An instruction fetch (kind 2) ignores the ASI. At trap level 0 it selects kernel (1) or user (0) mode from `priv`, with the primary context. At any nonzero trap level it selects nucleus mode (3) with context 0. `little_end` and `secondary` are 0 for a fetch.
- R9: `user` is 1 for modes 0 and 4 and for no other mode.
- R10: For a decoded load or store, `little_end` equals ASI bit 3.
- R11: Any other ASI on a load or store, and any access of kind 3, gives `unhandled`=1, mode 7, context 0 and every other flag 0.
- R12: The outputs follow an input strobe after exactly one clock, with `out_valid`=1. On a cycle without a strobe, `out_valid` is 0 on the next cycle and the decoded fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Access strobe |
| asi | input | 8 | Address-space identifier |
| kind | input | 2 | 0 load, 1 store, 2 instruction fetch, 3 reserved |
| priv | input | 1 | Privileged state bit |
| trap_lvl | input | 3 | Current trap level |
| dmmu_en | input | 1 | Data MMU enable |
| pri_ctx | input | 16 | Primary context register |
| sec_ctx | input | 16 | Secondary context register |
| lookup_fail | input | 1 | Translation failed for this access |
| out_valid | output | 1 | Decoded result valid |
| mode | output | 3 | Translation mode index |
| ctx | output | 13 | Context number |
| user | output | 1 | User-privilege translation |
| little_end | output | 1 | Little-endian access |
| secondary | output | 1 | Secondary-space access |
| nofault | output | 1 | No-fault load |
| nf_zero | output | 1 | Force zero result, no trap |
| bypass | output | 1 | Data access skips translation |
| unhandled | output | 1 | Identifier or kind not decoded |

## Verification
The assertions check on every cycle the relations between outputs that must always hold. These are: an unhandled result carries no mode and a zero context, nucleus mode always carries context 0, the user flag agrees with the secondary flag and the mode, a zero result is only forced for a no-fault load that was translated, kernel modes only follow a privileged strobe, and `out_valid` lags the strobe by one cycle. The bench sweeps every ASI value across all access kinds, both privilege levels, zero and nonzero trap levels, both MMU enable states and both lookup results. Only this sweep shows that each identifier maps to the right mode, context source and byte order. It also shows that a store with a no-fault identifier is rejected and that idle cycles hold the decoded fields.

// File: rtl/asi_ctx_pkg.sv
package asi_ctx_pkg;

    typedef enum logic [2:0] {
        MODE_USER       = 3'd0,
        MODE_KERNEL     = 3'd1,
        MODE_HYPV       = 3'd2,
        MODE_NUCLEUS    = 3'd3,
        MODE_USER_SEC   = 3'd4,
        MODE_KERNEL_SEC = 3'd5,
        MODE_NONE       = 3'd7
    } xlat_mode_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        GRP_NUCLEUS,
        GRP_AS_USER,
        GRP_PLAIN,
        GRP_NOFAULT,
        GRP_OTHER
    } asi_group_e;

endpackage

// File: rtl/asi_group_decode.sv
module asi_group_decode
    import asi_ctx_pkg::*;
#(
    parameter int ASI_W = 8
) (
    input  logic [ASI_W-1:0] asi,
    output asi_group_e       grp
);
    // Bits 0 (space) and 3 (byte order) are free within each group.
    localparam int FREE_MASK = 'h09;

    logic [ASI_W-1:0] base;

    always_comb begin
        base = asi & ~ASI_W'(FREE_MASK);
        grp  = GRP_OTHER;
        if (asi == ASI_W'('h04) || asi == ASI_W'('h0C)) grp = GRP_NUCLEUS;
        else if (base == ASI_W'('h10))                  grp = GRP_AS_USER;
        else if (base == ASI_W'('h80))                  grp = GRP_PLAIN;
        else if (base == ASI_W'('h82))                  grp = GRP_NOFAULT;
    end
endmodule

// File: rtl/asi_mode_select.sv
module asi_mode_select
    import asi_ctx_pkg::*;
(
    input  asi_group_e grp,
    input  logic       space_bit,
    input  logic       order_bit,
    input  acc_kind_e  kind,
    input  logic       priv,
    input  logic       tl_zero,
    output xlat_mode_e mode,
    output logic       le,
    output logic       nofault,
    output logic       unhandled
);
    xlat_mode_e priv_mode;

    always_comb begin
        if (priv) priv_mode = space_bit ? MODE_KERNEL_SEC : MODE_KERNEL;
        else      priv_mode = space_bit ? MODE_USER_SEC : MODE_USER;

        mode      = MODE_NONE;
        le        = 1'b0;
        nofault   = 1'b0;
        unhandled = 1'b0;
        case (kind)
            KIND_FETCH: begin
                if (tl_zero) mode = priv ? MODE_KERNEL : MODE_USER;
                else         mode = MODE_NUCLEUS;
            end
            KIND_LOAD, KIND_STORE: begin
                case (grp)
                    GRP_NUCLEUS: mode = MODE_NUCLEUS;
                    GRP_AS_USER: mode = space_bit ? MODE_USER_SEC : MODE_USER;
                    GRP_PLAIN:   mode = priv_mode;
                    GRP_NOFAULT: begin
                        if (kind == KIND_LOAD) begin
                            mode    = priv_mode;
                            nofault = 1'b1;
                        end else begin
                            unhandled = 1'b1;
                        end
                    end
                    default:     unhandled = 1'b1;
                endcase
                le = order_bit && !unhandled;
            end
            default: unhandled = 1'b1;
        endcase
    end
endmodule

// File: rtl/asi_ctx_select.sv
module asi_ctx_select
    import asi_ctx_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CTX_W = 13
) (
    input  xlat_mode_e       mode,
    input  logic [REG_W-1:0] pri_reg,
    input  logic [REG_W-1:0] sec_reg,
    output logic [CTX_W-1:0] ctx
);
    always_comb begin
        case (mode)
            MODE_USER, MODE_KERNEL:         ctx = pri_reg[CTX_W-1:0];
            MODE_USER_SEC, MODE_KERNEL_SEC: ctx = sec_reg[CTX_W-1:0];
            default:                        ctx = '0;
        endcase
    end
endmodule

// File: rtl/asi_ctx_decoder.sv
module asi_ctx_decoder
    import asi_ctx_pkg::*;
#(
    parameter int ASI_W = 8,
    parameter int TL_W  = 3,
    parameter int REG_W = 16,
    parameter int CTX_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ASI_W-1:0] asi,
    input  logic [1:0]       kind,
    input  logic             priv,
    input  logic [TL_W-1:0]  trap_lvl,
    input  logic             dmmu_en,
    input  logic [REG_W-1:0] pri_ctx,
    input  logic [REG_W-1:0] sec_ctx,
    input  logic             lookup_fail,
    output logic             out_valid,
    output logic [2:0]       mode,
    output logic [CTX_W-1:0] ctx,
    output logic             user,
    output logic             little_end,
    output logic             secondary,
    output logic             nofault,
    output logic             nf_zero,
    output logic             bypass,
    output logic             unhandled
);
    localparam int SPACE_BIT = 0;
    localparam int ORDER_BIT = 3;

    typedef struct packed {
        logic             vld;
        xlat_mode_e       mode;
        logic [CTX_W-1:0] ctx;
        logic             user;
        logic             le;
        logic             sec;
        logic             nf;
        logic             nfz;
        logic             byp;
        logic             unh;
    } dec_t;

    asi_group_e grp;
    xlat_mode_e sel_mode;
    acc_kind_e  kind_e;
    logic       sel_le, sel_nf, sel_unh;
    logic [CTX_W-1:0] sel_ctx;
    dec_t       dec_d, dec_q;

    assign kind_e = acc_kind_e'(kind);

    asi_group_decode #(.ASI_W(ASI_W)) u_grp (
        .asi (asi),
        .grp (grp)
    );

    asi_mode_select u_mode (
        .grp       (grp),
        .space_bit (asi[SPACE_BIT]),
        .order_bit (asi[ORDER_BIT]),
        .kind      (kind_e),
        .priv      (priv),
        .tl_zero   (trap_lvl == '0),
        .mode      (sel_mode),
        .le        (sel_le),
        .nofault   (sel_nf),
        .unhandled (sel_unh)
    );

    asi_ctx_select #(.REG_W(REG_W), .CTX_W(CTX_W)) u_ctx (
        .mode    (sel_mode),
        .pri_reg (pri_ctx),
        .sec_reg (sec_ctx),
        .ctx     (sel_ctx)
    );

    always_comb begin
        dec_d     = dec_q;
        dec_d.vld = in_valid;
        if (in_valid) begin
            dec_d.mode = sel_mode;
            dec_d.ctx  = sel_ctx;
            dec_d.user = (sel_mode == MODE_USER) || (sel_mode == MODE_USER_SEC);
            dec_d.sec  = (sel_mode == MODE_USER_SEC) || (sel_mode == MODE_KERNEL_SEC);
            dec_d.le   = sel_le;
            dec_d.nf   = sel_nf;
            dec_d.unh  = sel_unh;
            dec_d.byp  = !sel_unh && !dmmu_en &&
                         (kind_e == KIND_LOAD || kind_e == KIND_STORE);
            dec_d.nfz  = sel_nf && lookup_fail && !dec_d.byp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dec_q <= '0;
        else        dec_q <= dec_d;
    end

    assign out_valid  = dec_q.vld;
    assign mode       = dec_q.mode;
    assign ctx        = dec_q.ctx;
    assign user       = dec_q.user;
    assign little_end = dec_q.le;
    assign secondary  = dec_q.sec;
    assign nofault    = dec_q.nf;
    assign nf_zero    = dec_q.nfz;
    assign bypass     = dec_q.byp;
    assign unhandled  = dec_q.unh;
endmodule

// File: rtl/asi_ctx_decoder_chk.sv
module asi_ctx_decoder_chk #(
    parameter int CTX_W = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             priv,
    input logic             out_valid,
    input logic [2:0]       mode,
    input logic [CTX_W-1:0] ctx,
    input logic             user,
    input logic             secondary,
    input logic             nofault,
    input logic             nf_zero,
    input logic             bypass,
    input logic             unhandled
);
    // R11
    unhandled_no_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unhandled |-> (mode == 3'd7 && ctx == '0 && !nofault && !bypass));
    // R2
    nucleus_ctx_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd3) |-> (ctx == '0));
    // R9
    user_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        user |-> (mode == 3'd0 || (mode == 3'd4 && secondary)));
    // R6
    nf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nf_zero |-> (nofault && !bypass));
    // R4
    kernel_needs_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !priv) |=> !(mode == 3'd1 || mode == 3'd5));
    // R12
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(mode) && $stable(ctx)));
endmodule

bind asi_ctx_decoder asi_ctx_decoder_chk #(.CTX_W(CTX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .priv      (priv),
    .out_valid (out_valid),
    .mode      (mode),
    .ctx       (ctx),
    .user      (user),
    .secondary (secondary),
    .nofault   (nofault),
    .nf_zero   (nf_zero),
    .bypass    (bypass),
    .unhandled (unhandled)
);

// File: tb/asi_ctx_decoder_tb.sv
`timescale 1ns/1ps
module asi_ctx_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  asi = '0;
    logic [1:0]  kind = '0;
    logic        priv = 1'b0;
    logic [2:0]  trap_lvl = '0;
    logic        dmmu_en = 1'b0;
    logic [15:0] pri_ctx = '0;
    logic [15:0] sec_ctx = '0;
    logic        lookup_fail = 1'b0;
    logic        out_valid, user, little_end, secondary, nofault, nf_zero, bypass, unhandled;
    logic [2:0]  mode;
    logic [12:0] ctx;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    asi_ctx_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .asi(asi), .kind(kind),
        .priv(priv), .trap_lvl(trap_lvl), .dmmu_en(dmmu_en), .pri_ctx(pri_ctx),
        .sec_ctx(sec_ctx), .lookup_fail(lookup_fail), .out_valid(out_valid),
        .mode(mode), .ctx(ctx), .user(user), .little_end(little_end),
        .secondary(secondary), .nofault(nofault), .nf_zero(nf_zero),
        .bypass(bypass), .unhandled(unhandled)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h asi=%02h kind=%0d priv=%0d tl=%0d",
                     req, what, act, exp, asi, kind, priv, trap_lvl);
        end
    endtask

    int e_mode, e_ctx, e_user, e_le, e_sec, e_nf, e_nfz, e_byp, e_unh;
    string mode_tag;

    // Expected result, from the requirements
    task automatic model();
        logic data;
        int pm;
        data = (kind < 2);
        pm = priv ? (asi[0] ? 5 : 1) : (asi[0] ? 4 : 0);
        e_mode = 7; e_unh = 0; e_nf = 0; e_le = 0; mode_tag = "R11";
        if (kind == 2) begin
            mode_tag = "R8";
            e_mode = (trap_lvl == 0) ? (priv ? 1 : 0) : 3;
        end else if (kind == 3) begin
            e_unh = 1;
        end else begin
            case (asi)
                8'h04, 8'h0C: begin e_mode = 3; mode_tag = "R2"; end
                8'h10, 8'h11, 8'h18, 8'h19: begin e_mode = asi[0] ? 4 : 0; mode_tag = "R3"; end
                8'h80, 8'h81, 8'h88, 8'h89: begin e_mode = pm; mode_tag = "R4"; end
                8'h82, 8'h83, 8'h8A, 8'h8B: begin
                    mode_tag = "R6";
                    if (kind == 0) begin e_mode = pm; e_nf = 1; end
                    else e_unh = 1;
                end
                default: e_unh = 1;
            endcase
            if (!e_unh) e_le = asi[3];
        end
        if (e_mode == 0 || e_mode == 1)      e_ctx = pri_ctx & 16'h1FFF;
        else if (e_mode == 4 || e_mode == 5) e_ctx = sec_ctx & 16'h1FFF;
        else                                 e_ctx = 0;
        e_sec  = (e_mode == 4 || e_mode == 5);
        e_user = (e_mode == 0 || e_mode == 4);
        e_byp  = (data && !e_unh && !dmmu_en);
        e_nfz  = (e_nf && lookup_fail && !e_byp);
    endtask

    task automatic check_all();
        chk("R12", "out_valid", out_valid, 1);
        chk(mode_tag, "mode", mode, e_mode);
        chk("R5", "ctx", ctx, e_ctx);
        chk("R5", "secondary", secondary, e_sec);
        chk("R9", "user", user, e_user);
        chk("R10", "little_end", little_end, e_le);
        chk("R6", "nofault", nofault, e_nf);
        chk("R6", "nf_zero", nf_zero, e_nfz);
        chk("R7", "bypass", bypass, e_byp);
        chk("R11", "unhandled", unhandled, e_unh);
    endtask

    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "reset out_valid", out_valid, 0);
        chk("R1", "reset mode", mode, 0);
        chk("R1", "reset ctx", ctx, 0);
        chk("R1", "reset unhandled", unhandled, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 256; a++) begin
            for (int v = 0; v < 64; v++) begin
                asi         = 8'(a);
                kind        = 2'(v & 3);
                priv        = v[2];
                trap_lvl    = v[3] ? 3'd5 : 3'd0;
                dmmu_en     = v[4];
                lookup_fail = v[5];
                pri_ctx     = 16'hE5A3 ^ 16'(a * 97 + v);
                sec_ctx     = 16'h9C3E ^ 16'(a * 31 + v * 7);
                in_valid    = 1'b1;
                model();
                @(negedge clk);
                check_all();
            end
            if ((a % 32) == 31) begin
                // R12 idle cycle: fields hold, out_valid drops
                in_valid = 1'b0;
                asi = 8'h04;
                kind = 2'd0;
                @(negedge clk);
                chk("R12", "idle out_valid", out_valid, 0);
                chk("R12", "idle mode hold", mode, e_mode);
                chk("R12", "idle ctx hold", ctx, e_ctx);
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule